// File: doc/BRIEF.md
# Configurable Binary Logic Cell

This block is a small, run-time configurable logic element for protection schemes. It takes four binary signals and, depending on the active parameter set, produces their OR, their AND, or the state of a bistable latch. In latch mode, inputs 0 and 1 together form the set condition and inputs 2 and 3 together form the clear condition. When both conditions are present, the clear condition wins. Each input can be inverted individually before it reaches the logic. A blocking input forces the result inactive in every mode.

Four parameter sets are offered to the block as a flat static vector. A 2-bit selector picks one of them at run time. The chosen set is captured in a register, so a new selection or a new slot content reaches the output on the second clock edge. The result itself is registered, so the output follows the inputs by one clock. The latch starts empty after reset, after blocking, and whenever the active mode changes.

Top module: `binlogic_cell`

## Requirements
- R1: While and right after synchronous reset, `out_o` is 0.
- R2: With mode code 0 (OR) active, `out_o` one clock after the inputs equals the OR of the four conditioned inputs.
- R3: With mode code 1 (AND) active, `out_o` one clock after the inputs equals the AND of the four conditioned inputs.
- R4: With mode code 2 (latch) active, the output goes to 1 when conditioned input 0 or 1 is high, and goes to 0 when conditioned input 2 or 3 is high. With none of these high, it keeps its value.
- R5: In latch mode, when a set and a clear condition are present in the same clock, the output goes to 0.
- R6: Bit i of a slot's inversion mask inverts input i before any mode logic. A conditioned input is `in_i[i]` XOR mask bit i.
- R7: When `block_i` is high, `out_o` is 0 on the next clock in every mode. The latch state is also cleared, so it stays 0 after release until it is set again.
- R8: Slot k occupies `sets_i[6k+5:6k]`. Bits [6k+5:6k+4] hold the mode code and bits [6k+3:6k] hold the mask. `sel_i` picks the slot, and a change takes effect on the second rising edge after it.
- R9: A change of the active mode code clears the latch state, so entering latch mode without a set condition gives 0.
- R10: Mode code 3 is reserved and drives `out_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sets_i | input | 24 | Four parameter slots of 6 bits each: {mode[1:0], mask[3:0]} |
| sel_i | input | 2 | Active slot selector |
| in_i | input | 4 | Binary logic inputs |
| block_i | input | 1 | Blocking input; forces the output to 0 |
| out_o | output | 1 | Registered result |

## Verification
All 16 input combinations are swept against all 16 inversion masks, with and without blocking, in the OR, AND and reserved modes. This separates a dropped inversion bit, a swapped OR/AND decode and a leaking block. Pseudo-random input and block sequences drive latch mode under several masks. These sequences separate set-only, clear-only, simultaneous set and clear, and hold. Directed sequences cover the remaining behaviour. They show that slots are selected with the two-edge delay, that blocking clears rather than only masks, and that a mode switch empties the latch.

// File: rtl/binlogic_pkg.sv
package binlogic_pkg;
  localparam int unsigned NUM_IN = 4;

  typedef enum logic [1:0] {
    MODE_OR    = 2'd0,
    MODE_AND   = 2'd1,
    MODE_LATCH = 2'd2,
    MODE_OFF   = 2'd3
  } mode_e;

  typedef struct packed {
    mode_e             mode;
    logic [NUM_IN-1:0] inv;
  } pset_t;

  localparam int unsigned PSET_W = $bits(pset_t);
endpackage

// File: rtl/pset_select.sv
module pset_select
  import binlogic_pkg::*;
#(
  parameter int unsigned N_SETS = 4,
  localparam int unsigned SEL_W = (N_SETS > 1) ? $clog2(N_SETS) : 1,
  localparam int unsigned N_IDX = 1 << SEL_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_SETS*PSET_W-1:0] sets_i,
  input  logic [SEL_W-1:0]         sel_i,
  output pset_t                    cur_o,
  output logic                     chg_o
);
  pset_t slot [N_IDX];
  pset_t pick;

  genvar k;
  generate
    for (k = 0; k < N_IDX; k++) begin : g_slot
      if (k < N_SETS) begin : g_real
        assign slot[k] = pset_t'(sets_i[k*PSET_W +: PSET_W]);
      end else begin : g_fill
        assign slot[k] = pset_t'(sets_i[PSET_W-1:0]);
      end
    end
  endgenerate

  assign pick = slot[sel_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_o <= '{mode: MODE_OR, inv: '0};
      chg_o <= 1'b0;
    end else begin
      cur_o <= pick;
      chg_o <= (pick.mode != cur_o.mode);
    end
  end
endmodule

// File: rtl/input_cond.sv
module input_cond
  import binlogic_pkg::*;
(
  input  logic [NUM_IN-1:0] raw_i,
  input  logic [NUM_IN-1:0] inv_i,
  output logic [NUM_IN-1:0] cond_o
);
  genvar i;
  generate
    for (i = 0; i < NUM_IN; i++) begin : g_bit
      assign cond_o[i] = raw_i[i] ^ inv_i[i];
    end
  endgenerate
endmodule

// File: rtl/logic_core.sv
module logic_core
  import binlogic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  mode_e             mode_i,
  input  logic              chg_i,
  input  logic [NUM_IN-1:0] cond_i,
  input  logic              block_i,
  output logic              out_o
);
  localparam int unsigned HALF = NUM_IN / 2;

  logic set_c, clr_c, hold_c, nxt;

  assign set_c  = |cond_i[HALF-1:0];
  assign clr_c  = |cond_i[NUM_IN-1:HALF];
  assign hold_c = out_o & ~chg_i;

  always_comb begin
    nxt = 1'b0;
    if (!block_i) begin
      unique case (mode_i)
        MODE_OR:    nxt = |cond_i;
        MODE_AND:   nxt = &cond_i;
        MODE_LATCH: nxt = ~clr_c & (set_c | hold_c);
        default:    nxt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_o <= 1'b0;
    else     out_o <= nxt;
  end
endmodule

// File: rtl/binlogic_cell.sv
module binlogic_cell
  import binlogic_pkg::*;
#(
  parameter int unsigned N_SETS = 4,
  localparam int unsigned SEL_W = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_SETS*PSET_W-1:0] sets_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [NUM_IN-1:0]        in_i,
  input  logic                     block_i,
  output logic                     out_o
);
  pset_t             cur_set;
  logic              mode_chg;
  logic [NUM_IN-1:0] cond;

  pset_select #(.N_SETS(N_SETS)) u_sel (
    .clk    (clk),
    .rst    (rst),
    .sets_i (sets_i),
    .sel_i  (sel_i),
    .cur_o  (cur_set),
    .chg_o  (mode_chg)
  );

  input_cond u_cond (
    .raw_i  (in_i),
    .inv_i  (cur_set.inv),
    .cond_o (cond)
  );

  logic_core u_core (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (cur_set.mode),
    .chg_i   (mode_chg),
    .cond_i  (cond),
    .block_i (block_i),
    .out_o   (out_o)
  );
endmodule

// File: rtl/binlogic_cell_chk.sv
module binlogic_cell_chk
  import binlogic_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              block_i,
  input logic              out_o,
  input mode_e             cur_mode,
  input logic              mode_chg,
  input logic [NUM_IN-1:0] cond
);
  a_r7_block_low: assert property (@(posedge clk) disable iff (rst)
    block_i |=> !out_o);

  a_r2_or_idle: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MODE_OR && cond == '0) |=> !out_o);

  a_r3_and_all: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MODE_AND && &cond && !block_i) |=> out_o);

  a_r4_set: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MODE_LATCH && |cond[1:0] && !(|cond[3:2]) && !block_i) |=> out_o);

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MODE_LATCH && !mode_chg && cond == '0 && !block_i) |=> $stable(out_o));

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MODE_LATCH && |cond[3:2]) |=> !out_o);

  a_r9_mode_clear: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MODE_LATCH && mode_chg && !(|cond[1:0])) |=> !out_o);

  a_r10_reserved: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MODE_OFF) |=> !out_o);
endmodule

bind binlogic_cell binlogic_cell_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .block_i  (block_i),
  .out_o    (out_o),
  .cur_mode (cur_set.mode),
  .mode_chg (mode_chg),
  .cond     (cond)
);

// File: tb/test_binlogic_cell.sv
module test_binlogic_cell;
  logic        clk = 1'b0;
  logic        rst;
  logic [23:0] sets_i;
  logic [1:0]  sel_i;
  logic [3:0]  in_i;
  logic        block_i;
  logic        out_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  binlogic_cell i_binlogic_cell (
    .clk(clk), .rst(rst), .sets_i(sets_i), .sel_i(sel_i),
    .in_i(in_i), .block_i(block_i), .out_o(out_o)
  );

  task automatic check(input bit exp, input string req);
    n_chk++;
    if (out_o !== exp) begin
      n_err++;
      $display("FAIL %s: out_o=%b expected %b (sel=%0d in=%b blk=%b)",
               req, out_o, exp, sel_i, in_i, block_i);
    end
  endtask

  task automatic put_slot(input int k, input logic [1:0] mode, input logic [3:0] inv);
    sets_i[6*k +: 6] = {mode, inv};
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic step(input logic [3:0] x, input bit blk);
    in_i = x; block_i = blk;
    @(negedge clk);
  endtask

  function automatic bit comb_exp(input int mode, input logic [3:0] inv,
                                  input logic [3:0] x, input bit blk);
    logic [3:0] c;
    c = x ^ inv;
    if (blk) return 1'b0;
    case (mode)
      0:       return |c;
      1:       return &c;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    bit m;
    rst = 1'b1; sets_i = '0; sel_i = '0; in_i = 4'hF; block_i = 1'b0;
    @(negedge clk);
    check(1'b0, "R1 during reset");
    @(negedge clk);
    rst = 1'b0; in_i = 4'h0;
    @(negedge clk);
    check(1'b0, "R1 after reset");

    // R8: distinct slots, selector and two-edge delay
    put_slot(0, 2'd0, 4'h0); put_slot(1, 2'd1, 4'h0);
    put_slot(2, 2'd3, 4'h0); put_slot(3, 2'd0, 4'hF);
    for (int s = 0; s < 4; s++) begin
      sel_i = 2'(s); in_i = 4'hF; settle(); step(4'hF, 0);
      check(s < 2, "R8 slot pick in=1111");
      step(4'h0, 0);
      check(s == 3, "R8 slot pick in=0000");
    end
    sel_i = 2'd2; in_i = 4'hF; settle();
    sel_i = 2'd0;
    @(negedge clk); check(1'b0, "R8 first edge keeps old slot");
    @(negedge clk); check(1'b1, "R8 second edge applies new slot");

    // R2 R3 R6 R7 R10: exhaustive sweep on slot 0
    sel_i = 2'd0;
    for (int md = 0; md < 4; md++) begin
      if (md == 2) continue;
      for (int inv = 0; inv < 16; inv++) begin
        put_slot(0, 2'(md), 4'(inv)); in_i = 4'h0; block_i = 0; settle();
        for (int blk = 0; blk < 2; blk++)
          for (int x = 0; x < 16; x++) begin
            step(4'(x), blk[0]);
            check(comb_exp(md, 4'(inv), 4'(x), blk[0]),
                  blk ? "R7 block" : (md == 0 ? "R2 or/R6 inv" :
                                     (md == 1 ? "R3 and/R6 inv" : "R10 reserved")));
          end
      end
    end

    // R9: a mode change empties the latch
    put_slot(0, 2'd0, 4'h1); step(4'h0, 0); settle();
    check(1'b1, "R9 precondition or via inversion");
    put_slot(0, 2'd2, 4'h0);
    @(negedge clk); check(1'b1, "R9 old mode still one edge");
    @(negedge clk); check(1'b0, "R9 latch cleared on mode change");

    // R7: blocking clears the latch, not only masks it
    step(4'h1, 0); check(1'b1, "R4 set");
    step(4'h0, 1); check(1'b0, "R7 block in latch mode");
    step(4'h0, 0); check(1'b0, "R7 latch stays cleared after block");
    step(4'h5, 0); check(1'b0, "R5 set and clear together");

    // R4 R5 R6 R7: pseudo-random latch runs
    lfsr = 16'hACE1;
    for (int r = 0; r < 3; r++) begin
      logic [3:0] inv;
      inv = (r == 0) ? 4'h0 : ((r == 1) ? 4'hA : 4'hC);
      put_slot(0, 2'd0, 4'h0); step(4'h0, 0); settle();
      put_slot(0, 2'd2, inv); settle(); settle();
      m = 0;
      for (int t = 0; t < 120; t++) begin
        logic [3:0] x, c;
        bit blk;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        x = lfsr[3:0]; blk = (lfsr[9:7] == 3'd0);
        c = x ^ inv;
        if (blk) m = 0;
        else if (|c[3:2]) m = 0;
        else if (|c[1:0]) m = 1;
        step(x, blk);
        check(m, blk ? "R7 latch block" : ((|c[3:2] && |c[1:0]) ? "R5 clear wins" : "R4 latch/R6 inv"));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end
endmodule